// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block manages protection and power state for a driver with several H-bridges. It takes an active-low reset pin, an active-low sleep pin, one overcurrent flag per bridge from the analog current limiters, an overtemperature flag and an undervoltage flag. All of these inputs are asynchronous. From them it produces a per-bridge enable, a global logic reset, a run enable that gates the internal oscillator and charge pump, and an output-enable for an open-drain fault pin. The fault pin is pulled low whenever the output-enable is high.

Overcurrent is treated as a hard fault. A flag must persist for longer than a qualification window. Once it does, the fault is latched for that bridge alone and stays latched until the reset pin is pulsed or the supply drops. Overtemperature is a soft fault: it blocks every bridge only while the flag is high. Undervoltage behaves as a full power-on reset. Leaving sleep starts a timed wake-up delay before any bridge is enabled again.

All asynchronous inputs pass through a two-stage synchronizer, and every output is registered. The overcurrent window and the wake-up delay are parameters in clock cycles, called OC_QUAL_CYCLES and WAKE_CYCLES.

Top module: `mdfs_fault_supervisor`

## Requirements
- R1: After the synchronous system reset, and for as long as the reset pin is low, logic_rst is 1, bridge_en is all zero and fault_oe is 0. Overcurrent and overtemperature flags have no effect during this time.
- R2: With both pins high and no flags, every bridge_en bit is 1 from the fourth clock after the reset pin rises. In this state logic_rst is 0 and run_en is 1.
- R3: An overcurrent flag is qualified only if it is sampled high on more than OC_QUAL_CYCLES consecutive cycles. A flag held for exactly OC_QUAL_CYCLES cycles has no effect. Any low sample restarts the count. With the flag held continuously, the outputs change on clock 4+OC_QUAL_CYCLES after the flag rises.
- R4: A qualified overcurrent clears bridge_en for that bridge only (bit i belongs to flag bit i) and sets fault_oe. Both stay that way after the flag falls, and through any overtemperature episode.
- R5: A latched overcurrent is cleared by a low reset pin, even one lasting a single cycle, or by the undervoltage flag. It is cleared by nothing else.
- R6: While overtemperature is high, all bridge_en bits are 0 and fault_oe is 1. Both change on the third clock after the flag rises, and both recover on the third clock after it falls, with no reset needed.
- R7: While undervoltage is high, logic_rst is 1, run_en is 0, bridge_en is 0 and fault_oe is 0. Latched faults are erased. Bridges return on the fourth clock after the flag falls.
- R8: While the sleep pin is low, run_en and bridge_en are 0. Overcurrent and overtemperature flags are ignored (nothing latches and no fault is reported). An overcurrent latched before sleep keeps fault_oe at 1.
- R9: When the sleep pin rises with the reset pin high, run_en rises on the third clock. bridge_en stays 0 until clock 4+WAKE_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_n_pin | input | 1 | Asynchronous active-low reset pin |
| sleep_n_pin | input | 1 | Asynchronous active-low sleep pin |
| oc_flag | input | NUM_BRIDGES | Overcurrent flag per bridge, asynchronous |
| ot_flag | input | 1 | Overtemperature flag, asynchronous |
| uv_flag | input | 1 | Undervoltage flag, asynchronous |
| bridge_en | output | NUM_BRIDGES | Enable per bridge |
| logic_rst | output | 1 | Global logic reset |
| run_en | output | 1 | Oscillator and charge pump enable |
| fault_oe | output | 1 | Open-drain pull-down enable for the fault pin |

## Verification
Some behaviours are checked by the assertions on every cycle:
- a low synchronized reset or undervoltage forces the bridges off and the logic reset on at the next clock;
- sleep stops the run enable;
- live overtemperature raises the fault output;
- a latched overcurrent never releases without its clear and always keeps its own bridge off;
- no bridge is enabled during the wake-up state.

Other behaviours can only be shown by the bench scenarios:
- the exact cycle counts for qualification and wake-up;
- the restart of the qualification count after a one-cycle dropout;
- the isolation of one bridge's fault from the other bridge;
- the retention of a latched fault across sleep.

// File: rtl/mdfs_pkg.sv
package mdfs_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_WAKE  = 2'd2,
    PS_RUN   = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/mdfs_sync.sv
module mdfs_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/mdfs_oc_qual.sv
module mdfs_oc_qual #(
  parameter int QUAL = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hold,
  input  logic oc_s,
  output logic latched
);
  localparam int CW = $clog2(QUAL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (hold || !oc_s) begin
      cnt <= '0;
    end else if (!latched) begin
      if (cnt == CW'(QUAL)) latched <= 1'b1;
      else                  cnt     <= cnt + 1'b1;
    end
  end

  AST_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (latched && !clr) |=> latched); // R4

  AST_OC_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(latched) |-> ($past(oc_s) && !$past(hold))); // R3

  AST_OC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> !latched); // R5
endmodule

// File: rtl/mdfs_wake_timer.sv
module mdfs_wake_timer #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == CW'(CYCLES - 1));

  AST_WAKE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < CW'(CYCLES))); // R9
endmodule

// File: rtl/mdfs_fault_supervisor.sv
module mdfs_fault_supervisor
  import mdfs_pkg::*;
#(
  parameter int NUM_BRIDGES    = 2,
  parameter int OC_QUAL_CYCLES = 150,
  parameter int WAKE_CYCLES    = 50000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rst_n_pin,
  input  logic                   sleep_n_pin,
  input  logic [NUM_BRIDGES-1:0] oc_flag,
  input  logic                   ot_flag,
  input  logic                   uv_flag,
  output logic [NUM_BRIDGES-1:0] bridge_en,
  output logic                   logic_rst,
  output logic                   run_en,
  output logic                   fault_oe
);
  localparam int SW = NUM_BRIDGES + 4;

  logic [SW-1:0] raw_in, synced;
  logic rstn_s, sleepn_s, ot_s, uv_s;
  logic [NUM_BRIDGES-1:0] oc_s, oc_latch, bridge_en_d;
  logic in_reset, active, run_ok, wake_done;
  pwr_state_t state;

  assign raw_in = {rst_n_pin, sleep_n_pin, ot_flag, uv_flag, oc_flag};

  mdfs_sync #(.WIDTH(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (synced)
  );

  assign rstn_s   = synced[SW-1];
  assign sleepn_s = synced[SW-2];
  assign ot_s     = synced[SW-3];
  assign uv_s     = synced[SW-4];
  assign oc_s     = synced[NUM_BRIDGES-1:0];

  assign in_reset = uv_s || !rstn_s;
  assign active   = ((state == PS_WAKE) || (state == PS_RUN)) && sleepn_s && !in_reset;
  assign run_ok   = (state == PS_RUN) && sleepn_s && !in_reset && !ot_s;

  mdfs_wake_timer #(.CYCLES(WAKE_CYCLES)) u_wake (
    .clk  (clk),
    .rst  (rst),
    .en   (state == PS_WAKE),
    .done (wake_done)
  );

  // Power state: undervoltage/reset > sleep > wake-up > run
  always_ff @(posedge clk) begin
    if (rst || in_reset) begin
      state <= PS_OFF;
    end else if (!sleepn_s) begin
      state <= PS_SLEEP;
    end else begin
      case (state)
        PS_OFF:   state <= PS_RUN;
        PS_SLEEP: state <= PS_WAKE;
        PS_WAKE:  if (wake_done) state <= PS_RUN;
        default:  state <= state;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_BRIDGES; i++) begin : g_bridge
    mdfs_oc_qual #(.QUAL(OC_QUAL_CYCLES)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .clr     (in_reset),
      .hold    (!active),
      .oc_s    (oc_s[i]),
      .latched (oc_latch[i])
    );

    assign bridge_en_d[i] = run_ok && !oc_latch[i];

    AST_OC_BRIDGE_OFF: assert property (@(posedge clk) disable iff (rst)
      oc_latch[i] |=> !bridge_en[i]); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bridge_en <= '0;
      logic_rst <= 1'b1;
      run_en    <= 1'b0;
      fault_oe  <= 1'b0;
    end else begin
      bridge_en <= bridge_en_d;
      logic_rst <= in_reset;
      run_en    <= !uv_s && sleepn_s;
      fault_oe  <= !in_reset && ((|oc_latch) || (sleepn_s && ot_s));
    end
  end

  AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    in_reset |=> (bridge_en == '0 && logic_rst && !fault_oe)); // R1

  AST_SLEEP_STOPS: assert property (@(posedge clk) disable iff (rst)
    !sleepn_s |=> (!run_en && bridge_en == '0)); // R8

  AST_OT_FAULT: assert property (@(posedge clk) disable iff (rst)
    (ot_s && sleepn_s && !in_reset) |=> (fault_oe && bridge_en == '0)); // R6

  AST_UV_DOWN: assert property (@(posedge clk) disable iff (rst)
    uv_s |=> (!run_en && !fault_oe)); // R7

  AST_WAKE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (state == PS_WAKE) |-> (bridge_en == '0)); // R9
endmodule

// File: tb/sim_mdfs_fault_supervisor.sv
module sim_mdfs_fault_supervisor;
  localparam int NB   = 2;
  localparam int QUAL = 3;
  localparam int WAKE = 10;
  localparam int NV   = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_n_pin = 1'b0, sleep_n_pin = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0;
  logic [NB-1:0] oc_flag = '0;
  logic [NB-1:0] bridge_en;
  logic logic_rst, run_en, fault_oe;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mdfs_fault_supervisor #(
    .NUM_BRIDGES(NB), .OC_QUAL_CYCLES(QUAL), .WAKE_CYCLES(WAKE)
  ) u0 (
    .clk(clk), .rst(rst), .rst_n_pin(rst_n_pin), .sleep_n_pin(sleep_n_pin),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
    .bridge_en(bridge_en), .logic_rst(logic_rst), .run_en(run_en), .fault_oe(fault_oe)
  );

  // {rstn, sleepn, oc[1:0], ot, uv, hold[7:0], req[3:0], en[1:0], lrst, run, fault}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b1,2'b00,1'b0,1'b0,8'd6, 4'd1,2'b00,1'b1,1'b1,1'b0}, // R1 reset pin low
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd6, 4'd2,2'b11,1'b0,1'b1,1'b0}, // R2 run
    {1'b1,1'b1,2'b01,1'b0,1'b0,8'd3, 4'd3,2'b11,1'b0,1'b1,1'b0}, // R3 short pulse
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd8, 4'd3,2'b11,1'b0,1'b1,1'b0}, // R3 no latch
    {1'b1,1'b1,2'b01,1'b0,1'b0,8'd4, 4'd3,2'b11,1'b0,1'b1,1'b0}, // R3 long pulse
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd8, 4'd4,2'b10,1'b0,1'b1,1'b1}, // R4 bridge0 latched
    {1'b1,1'b1,2'b00,1'b1,1'b0,8'd5, 4'd6,2'b00,1'b0,1'b1,1'b1}, // R6 overtemp
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd5, 4'd4,2'b10,1'b0,1'b1,1'b1}, // R4 survives OT
    {1'b0,1'b1,2'b00,1'b0,1'b0,8'd5, 4'd5,2'b00,1'b1,1'b1,1'b0}, // R5 reset pin
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd6, 4'd5,2'b11,1'b0,1'b1,1'b0}, // R5 cleared
    {1'b1,1'b1,2'b00,1'b1,1'b0,8'd5, 4'd6,2'b00,1'b0,1'b1,1'b1}, // R6
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd5, 4'd6,2'b11,1'b0,1'b1,1'b0}, // R6 auto recover
    {1'b1,1'b1,2'b10,1'b0,1'b0,8'd8, 4'd4,2'b01,1'b0,1'b1,1'b1}, // R4 bridge1 latched
    {1'b1,1'b1,2'b00,1'b0,1'b1,8'd5, 4'd7,2'b00,1'b1,1'b0,1'b0}, // R7 undervoltage
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd6, 4'd7,2'b11,1'b0,1'b1,1'b0}, // R7 latch erased
    {1'b1,1'b0,2'b00,1'b0,1'b0,8'd5, 4'd8,2'b00,1'b0,1'b0,1'b0}, // R8 sleep
    {1'b1,1'b0,2'b11,1'b1,1'b0,8'd8, 4'd8,2'b00,1'b0,1'b0,1'b0}, // R8 flags ignored
    {1'b1,1'b0,2'b00,1'b0,1'b0,8'd3, 4'd8,2'b00,1'b0,1'b0,1'b0}, // R8
    {1'b1,1'b1,2'b00,1'b0,1'b0,8'd20,4'd9,2'b11,1'b0,1'b1,1'b0}  // R9 wake, nothing latched
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [1:0] en, input logic lr,
                       input logic run, input logic flt);
    checks++;
    if ({bridge_en, logic_rst, run_en, fault_oe} !== {en, lr, run, flt}) begin
      errors++;
      $display("FAIL %s: got en=%b rst=%b run=%b flt=%b, expected en=%b rst=%b run=%b flt=%b",
               tag, bridge_en, logic_rst, run_en, fault_oe, en, lr, run, flt);
    end
  endtask

  initial begin
    tick(3);
    check("R1", 2'b00, 1'b1, 1'b0, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      {rst_n_pin, sleep_n_pin, oc_flag, ot_flag, uv_flag} = VEC[k][22:17];
      tick(int'(VEC[k][16:9]));
      check($sformatf("R%0d", VEC[k][8:5]), VEC[k][4:3], VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R6 exact latency of overtemperature entry and exit
    ot_flag = 1'b1; tick(2);
    check("R6", 2'b11, 1'b0, 1'b1, 1'b0);
    tick(1);
    check("R6", 2'b00, 1'b0, 1'b1, 1'b1);
    ot_flag = 1'b0; tick(2);
    check("R6", 2'b00, 1'b0, 1'b1, 1'b1);
    tick(1);
    check("R6", 2'b11, 1'b0, 1'b1, 1'b0);

    // R3 one-cycle dropout restarts the qualification count
    oc_flag = 2'b01; tick(3);
    oc_flag = 2'b00; tick(1);
    oc_flag = 2'b01; tick(3);
    oc_flag = 2'b00; tick(8);
    check("R3", 2'b11, 1'b0, 1'b1, 1'b0);

    // R3 exact qualification cycle with a held flag
    oc_flag = 2'b01; tick(6);
    check("R3", 2'b11, 1'b0, 1'b1, 1'b0);
    tick(1);
    check("R3", 2'b10, 1'b0, 1'b1, 1'b1);
    oc_flag = 2'b00; tick(4);

    // R8 latched fault retained through sleep
    sleep_n_pin = 1'b0; tick(5);
    check("R8", 2'b00, 1'b0, 1'b0, 1'b1);

    // R9 wake-up timing
    sleep_n_pin = 1'b1; tick(2);
    check("R9", 2'b00, 1'b0, 1'b0, 1'b1);
    tick(1);
    check("R9", 2'b00, 1'b0, 1'b1, 1'b1);
    tick(WAKE);
    check("R9", 2'b00, 1'b0, 1'b1, 1'b1);
    tick(1);
    check("R9", 2'b10, 1'b0, 1'b1, 1'b1);

    // R5 single-cycle reset pulse clears the latch
    rst_n_pin = 1'b0; tick(1);
    rst_n_pin = 1'b1; tick(8);
    check("R5", 2'b11, 1'b0, 1'b1, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule